// File: doc/BRIEF.md
# Converter Power-State Arbiter

This block decides whether the analog conversion circuitry of a converter is powered. Two sources request power-down. The first is a hardware pin, which arrives asynchronously and is synchronized inside the block. The second is a pair of decoded serial-port strobes that request software power-up and software power-down. The digital side stays powered throughout, so strobes are still accepted and acted on while the analog side is off.

The two sources do not have equal weight. A high pin always forces the analog side off, and a software power-up cannot override it. A software power-down takes effect whatever level the pin has. A software power-down is cleared by a software power-up or by the pin going high and then low again. The falling edge of the synchronized pin acts as the wake event.

If the analog side switches off while a conversion is busy, the block issues a one-cycle abort pulse and raises a flag that marks the result data as unreliable. The flag stays set until a later conversion completes normally with power on.

Top module: `pwrdn_arbiter`

## Requirements
- R1: After reset, analog_en is 1, conv_abort is 0 and result_invalid is 0, and the software power state is "up".
- R2: pd_pin high turns analog_en to 0 on the third rising clock edge after the pin changes (SYNC_STAGES=2 synchronizer plus one register). analog_en stays 0 while the synchronized pin is high, even if sw_up_stb is pulsed.
- R3: A one-cycle sw_down_stb sets the software state to "down" at the next rising edge, and analog_en is 0 from that edge on, for either pin level.
- R4: A sw_up_stb clears the software state at the next edge. analog_en returns to 1 at that edge if the synchronized pin is low. Strobes are acted on while powered down.
- R5: A high-then-low sequence on pd_pin clears a software power-down. analog_en returns to 1 on the third rising edge after the pin falls.
- R6: When sw_down_stb arrives in the same cycle as sw_up_stb, or in the same cycle as a synchronized pin fall, the power-down wins.
- R7: conv_abort pulses high for exactly one cycle, at the edge where analog_en goes from 1 to 0, if conv_busy was 1 in the cycle before that edge. There is no pulse when conv_busy is 0 or when analog_en was already 0.
- R8: result_invalid becomes 1 together with conv_abort. It clears only on a conv_done pulse sampled while analog_en is 1. A conv_done sampled while analog_en is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin | input | 1 | Raw hardware power-down pin, active high, asynchronous |
| sw_up_stb | input | 1 | Decoded software power-up instruction, one cycle |
| sw_down_stb | input | 1 | Decoded software power-down instruction, one cycle |
| conv_busy | input | 1 | A conversion is in progress |
| conv_done | input | 1 | A conversion finished, one cycle |
| analog_en | output | 1 | Analog conversion circuitry enabled |
| conv_abort | output | 1 | One-cycle pulse: the running conversion was cut off |
| result_invalid | output | 1 | Result data is unreliable after an aborted conversion |

## Verification
The bench builds the block with the default SYNC_STAGES=2 and derives every pin latency from that value. This keeps each pin-to-output delay short enough to sample at a known edge. It also lets a sweep cover all pairings of starting software state, pin level and software command (none, up or down), each followed by a pin release, with the expected power state computed arithmetically. Directed sequences cover the edge-exact timing of the abort pulse, conflicting strobes in one cycle, a power-down strobe during a pin fall, and conv_done arriving while powered down.

// File: rtl/pdarb_pkg.sv
package pdarb_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_UP   = 2'd1,
        CMD_DOWN = 2'd2
    } sw_cmd_e;

    typedef struct packed {
        logic sw_down;
        logic analog_en;
    } policy_st_t;

    typedef struct packed {
        logic abort;
        logic invalid;
    } result_st_t;

endpackage

// File: rtl/pdarb_pin_sync.sv
module pdarb_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic level,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t          cur_q;
    sync_st_t          nxt_d;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = pin_async;
        end else begin : g_multi
            assign chain_d = {cur_q.chain[STAGES-2:0], pin_async};
        end
    endgenerate

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = chain_d;
        nxt_d.prev  = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level = cur_q.chain[STAGES-1];
    assign fall  = cur_q.prev & ~cur_q.chain[STAGES-1];
endmodule

// File: rtl/pdarb_policy.sv
module pdarb_policy
    import pdarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_level,
    input  logic pin_fall,
    input  logic sw_up_stb,
    input  logic sw_down_stb,
    output logic analog_en,
    output logic analog_en_next,
    output logic sw_down
);
    policy_st_t st_q;
    policy_st_t st_d;
    sw_cmd_e    cmd;

    // Power-down outranks every wake source in the same cycle.
    always_comb begin
        if (sw_down_stb) begin
            cmd = CMD_DOWN;
        end else if (sw_up_stb || pin_fall) begin
            cmd = CMD_UP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_DOWN: st_d.sw_down = 1'b1;
            CMD_UP:   st_d.sw_down = 1'b0;
            default:  st_d.sw_down = st_q.sw_down;
        endcase
        st_d.analog_en = ~pin_level & ~st_d.sw_down;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sw_down: 1'b0, analog_en: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign analog_en      = st_q.analog_en;
    assign analog_en_next = st_d.analog_en;
    assign sw_down        = st_q.sw_down;
endmodule

// File: rtl/pdarb_result.sv
module pdarb_result
    import pdarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic analog_en,
    input  logic analog_en_next,
    input  logic conv_busy,
    input  logic conv_done,
    output logic conv_abort,
    output logic result_invalid
);
    result_st_t st_q;
    result_st_t st_d;
    logic       drop;

    assign drop = analog_en & ~analog_en_next;

    always_comb begin
        st_d       = st_q;
        st_d.abort = drop & conv_busy;
        if (st_d.abort) begin
            st_d.invalid = 1'b1;
        end else if (conv_done && analog_en) begin
            st_d.invalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_abort     = st_q.abort;
    assign result_invalid = st_q.invalid;
endmodule

// File: rtl/pwrdn_arbiter.sv
module pwrdn_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_pin,
    input  logic sw_up_stb,
    input  logic sw_down_stb,
    input  logic conv_busy,
    input  logic conv_done,
    output logic analog_en,
    output logic conv_abort,
    output logic result_invalid
);
    logic pin_level;
    logic pin_fall;
    logic analog_en_next;
    logic sw_down;

    pdarb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pd_pin),
        .level     (pin_level),
        .fall      (pin_fall)
    );

    pdarb_policy u_policy (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_level      (pin_level),
        .pin_fall       (pin_fall),
        .sw_up_stb      (sw_up_stb),
        .sw_down_stb    (sw_down_stb),
        .analog_en      (analog_en),
        .analog_en_next (analog_en_next),
        .sw_down        (sw_down)
    );

    pdarb_result u_result (
        .clk            (clk),
        .rst_n          (rst_n),
        .analog_en      (analog_en),
        .analog_en_next (analog_en_next),
        .conv_busy      (conv_busy),
        .conv_done      (conv_done),
        .conv_abort     (conv_abort),
        .result_invalid (result_invalid)
    );
endmodule

// File: rtl/pwrdn_arbiter_chk.sv
module pwrdn_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_up_stb,
    input logic sw_down_stb,
    input logic conv_busy,
    input logic conv_done,
    input logic analog_en,
    input logic conv_abort,
    input logic result_invalid,
    input logic pin_level,
    input logic pin_fall,
    input logic sw_down
);
    // R2: a synchronized high pin keeps the analog side off
    a_r2_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        pin_level |=> !analog_en);

    // R3: software power-down acts at the next edge
    a_r3_sw_down_acts: assert property (@(posedge clk) disable iff (!rst_n)
        sw_down_stb |=> (sw_down && !analog_en));

    // R4: software power-up without a competing down clears the state
    a_r4_sw_up_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_up_stb && !sw_down_stb) |=> !sw_down);

    // R5: pin fall wakes from a software power-down
    a_r5_pin_fall_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fall && !sw_down_stb) |=> (!sw_down && analog_en));

    // R7: abort only on a busy power drop, and only one cycle long
    a_r7_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> ($past(analog_en) && !analog_en && $past(conv_busy)));
    a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> !conv_abort);

    // R8: invalid flag set by abort, cleared only by a powered completion
    a_r8_invalid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_invalid) |-> conv_abort);
    a_r8_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (result_invalid && !(conv_done && analog_en)) |=> result_invalid);
endmodule

bind pwrdn_arbiter pwrdn_arbiter_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_up_stb      (sw_up_stb),
    .sw_down_stb    (sw_down_stb),
    .conv_busy      (conv_busy),
    .conv_done      (conv_done),
    .analog_en      (analog_en),
    .conv_abort     (conv_abort),
    .result_invalid (result_invalid),
    .pin_level      (pin_level),
    .pin_fall       (pin_fall),
    .sw_down        (sw_down)
);

// File: tb/tb_pwrdn_arbiter.sv
`timescale 1ns/1ps
module tb_pwrdn_arbiter;
    localparam int STAGES = 2;
    localparam int LAT    = STAGES + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin = 1'b0;
    logic sw_up_stb = 1'b0;
    logic sw_down_stb = 1'b0;
    logic conv_busy = 1'b0;
    logic conv_done = 1'b0;
    logic analog_en;
    logic conv_abort;
    logic result_invalid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwrdn_arbiter #(.SYNC_STAGES(STAGES)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pd_pin         (pd_pin),
        .sw_up_stb      (sw_up_stb),
        .sw_down_stb    (sw_down_stb),
        .conv_busy      (conv_busy),
        .conv_done      (conv_done),
        .analog_en      (analog_en),
        .conv_abort     (conv_abort),
        .result_invalid (result_invalid)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        sw_up_stb = 1'b1;
        tick(1);
        sw_up_stb = 1'b0;
    endtask

    task automatic pulse_down();
        sw_down_stb = 1'b1;
        tick(1);
        sw_down_stb = 1'b0;
    endtask

    task automatic pulse_done();
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "analog_en after reset", analog_en, 1'b1);
        chk("R1", "conv_abort after reset", conv_abort, 1'b0);
        chk("R1", "result_invalid after reset", result_invalid, 1'b0);
        tick(2);

        // R2 pin latency and override of software power-up
        pd_pin = 1'b1;
        tick(LAT - 1);
        chk("R2", "analog_en before pin latency", analog_en, 1'b1);
        tick(1);
        chk("R2", "analog_en at pin latency", analog_en, 1'b0);
        pulse_up();
        chk("R2", "sw up while pin high", analog_en, 1'b0);
        tick(3);
        chk("R2", "still off while pin high", analog_en, 1'b0);
        pd_pin = 1'b0;
        tick(LAT);
        chk("R2", "pin released", analog_en, 1'b1);

        // R3 / R4 software down and up with pin low
        pulse_down();
        chk("R3", "sw down with pin low", analog_en, 1'b0);
        chk("R7", "no abort when idle", conv_abort, 1'b0);
        tick(2);
        pulse_up();
        chk("R4", "sw up with pin low", analog_en, 1'b1);

        // R5 wake by pin toggle
        pulse_down();
        pd_pin = 1'b1;
        tick(LAT + 1);
        chk("R5", "off while pin high after sw down", analog_en, 1'b0);
        pd_pin = 1'b0;
        tick(LAT - 1);
        chk("R5", "still off before wake latency", analog_en, 1'b0);
        tick(1);
        chk("R5", "wake by pin high-then-low", analog_en, 1'b1);

        // R6 conflicting strobes
        sw_up_stb = 1'b1;
        sw_down_stb = 1'b1;
        tick(1);
        sw_up_stb = 1'b0;
        sw_down_stb = 1'b0;
        chk("R6", "down wins over up", analog_en, 1'b0);
        pd_pin = 1'b1;
        tick(LAT + 1);
        pd_pin = 1'b0;
        tick(STAGES);
        pulse_down();
        chk("R6", "down wins over pin fall", analog_en, 1'b0);
        tick(3);
        chk("R6", "down still held after pin fall", analog_en, 1'b0);
        pulse_up();
        chk("R4", "recover after conflict", analog_en, 1'b1);

        // R7 / R8 abort by software power-down while busy
        conv_busy = 1'b1;
        pulse_down();
        chk("R7", "abort on busy sw down", conv_abort, 1'b1);
        chk("R8", "invalid set with abort", result_invalid, 1'b1);
        tick(1);
        chk("R7", "abort lasts one cycle", conv_abort, 1'b0);
        pulse_down();
        chk("R7", "no abort when already down", conv_abort, 1'b0);
        conv_busy = 1'b0;
        pulse_done();
        chk("R8", "conv_done while down ignored", result_invalid, 1'b1);
        pulse_up();
        chk("R8", "invalid held after power-up", result_invalid, 1'b1);
        pulse_done();
        chk("R8", "invalid cleared by powered completion", result_invalid, 1'b0);

        // R7 abort by pin while busy
        conv_busy = 1'b1;
        pd_pin = 1'b1;
        tick(LAT - 1);
        chk("R7", "no abort before pin latency", conv_abort, 1'b0);
        tick(1);
        chk("R7", "abort on busy pin down", conv_abort, 1'b1);
        chk("R8", "invalid set by pin abort", result_invalid, 1'b1);
        tick(1);
        chk("R7", "pin abort one cycle", conv_abort, 1'b0);
        conv_busy = 1'b0;
        pd_pin = 1'b0;
        tick(LAT + 1);
        pulse_done();
        chk("R8", "invalid cleared after pin abort", result_invalid, 1'b0);

        // Sweep: start state x pin level x command, then pin release (R2..R5)
        for (int ini = 0; ini < 2; ini++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 3; c++) begin
                    bit sw1;
                    bit sw2;
                    pd_pin = 1'b0;
                    tick(LAT + 1);
                    if (ini == 1) pulse_down(); else pulse_up();
                    tick(1);
                    pd_pin = p[0];
                    tick(LAT + 1);
                    if (c == 1) pulse_up();
                    else if (c == 2) pulse_down();
                    else tick(1);
                    sw1 = (c == 2) ? 1'b1 : ((c == 1) ? 1'b0 : ini[0]);
                    chk(p == 1 ? "R2" : (c == 2 ? "R3" : "R4"), "sweep after command",
                        analog_en, !p[0] && !sw1);
                    chk("R7", "sweep no abort when idle", conv_abort, 1'b0);
                    pd_pin = 1'b0;
                    tick(LAT + 1);
                    sw2 = p[0] ? 1'b0 : sw1;
                    chk(p == 1 ? "R5" : "R4", "sweep after pin release", analog_en, !sw2);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule